// File: doc/BRIEF.md
# Facility Data Link Byte Receiver

This block turns the serial data-link bits that a T1 framer recovers into whole bytes, one byte for every eight qualified bits. Each incoming bit comes with a one-cycle valid strobe. The block shifts the bits in with the least significant bit first. When a byte is complete it is copied into a holding register, so the host can read it while the next byte is still arriving.

At the moment a byte completes, it is compared with every programmable pattern register. A host can enable only the match interrupt and leave the link alone until a byte of interest arrives. Three sticky status flags report events: byte ready, pattern hit and overrun. Reading the status register clears the flags. A mask register selects which flags pull the registered active-low interrupt line low. At the T1 link rate a byte completes every 2 ms, and the host must read it within that window.

Top module: `fdl_byte_rx`

## Requirements
- R1: Bits are taken least significant bit first. After eight qualified bits, the data register (address 0) holds the completed byte, with the first received bit at bit 0.
- R2: The cycle after the eighth qualified bit, status bit 0 (byte ready) reads as 1.
- R3: If the completed byte equals either pattern register (address 3 or 4), status bit 1 (match) is set together with byte ready. Otherwise bit 1 is unchanged.
- R4: A read of the data register marks the byte as taken. If a byte completes while the previous one has not been taken, status bit 2 (overrun) is set and the data register holds the newer byte. A data read in the same cycle as a completion counts as taken, so no overrun is raised.
- R5: A read of the status register (address 1) returns the flags in bits 2:0 and clears them at that clock edge. A flag raised in the same cycle as that read stays set.
- R6: The mask register (address 2) has bits 2:0, one per status bit. irq_n_o is low exactly when some status bit and its mask bit are both 1. It changes only on a clock edge and is valid in the same cycle as the status it reflects.
- R7: After reset, all status bits, mask bits, the data register and both pattern registers read 0x00, and irq_n_o is high.
- R8: A bit presented while bit_vld_i is low has no effect on the assembled byte or on the bit count.
- R9: The pattern and mask registers read back the values written to them. Writes to the data and status addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_i | input | 1 | Recovered data-link bit |
| bit_vld_i | input | 1 | One-cycle qualifier for bit_i |
| reg_sel_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from reg_sel_i |
| irq_n_o | output | 1 | Registered active-low interrupt |

## Verification
The hardest cases to reach are the collisions, where a host read lands in the same cycle as the eighth bit. One collision is a status read meeting a new event, and the other is a data read meeting a new byte, which must not raise overrun. Directed tasks shift in seven bits, then assert the read strobe together with the final qualified bit, and compare the returned value and the following status with the bench model. Random bytes, random mask values, randomly skipped data reads, and idle gaps with junk on bit_i between valid bits cover the ordinary paths. Some random bytes are forced to equal a pattern.

// File: rtl/fdl_pkg.sv
package fdl_pkg;
  localparam int REG_AW   = 3;
  localparam int A_DATA   = 0;
  localparam int A_STAT   = 1;
  localparam int A_MASK   = 2;
  localparam int A_PAT0   = 3;
  localparam int ST_W     = 3;
  localparam int ST_FULL  = 0;
  localparam int ST_MATCH = 1;
  localparam int ST_OVR   = 2;
endpackage

// File: rtl/fdl_shift.sv
module fdl_shift #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              last;

  assign last   = (cnt_q == CNT_W'(BYTE_W-1));
  assign done_o = bit_vld_i & last;
  assign byte_o = {bit_i, sh_q[BYTE_W-1:1]};
  assign cnt_o  = cnt_q;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (bit_vld_i) begin
      sh_d  = {bit_i, sh_q[BYTE_W-1:1]};
      cnt_d = last ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/fdl_match.sv
module fdl_match #(
  parameter int BYTE_W  = 8,
  parameter int NUM_PAT = 2,
  parameter int AW      = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_i,
  input  logic [AW-1:0]                  sel_i,
  input  logic [BYTE_W-1:0]              wdata_i,
  input  logic [BYTE_W-1:0]              byte_i,
  output logic                           hit_o,
  output logic [NUM_PAT-1:0][BYTE_W-1:0] pat_o
);
  import fdl_pkg::*;

  logic [NUM_PAT-1:0] eq;

  for (genvar i = 0; i < NUM_PAT; i++) begin : g_pat
    logic [BYTE_W-1:0] pat_q, pat_d;
    logic              we;
    assign we = wr_i && (sel_i == AW'(A_PAT0 + i));
    always_comb begin
      pat_d = pat_q;
      if (we) pat_d = wdata_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pat_q <= '0;
      else        pat_q <= pat_d;
    end
    assign pat_o[i] = pat_q;
    assign eq[i]    = (byte_i == pat_q);
  end

  assign hit_o = |eq;
endmodule

// File: rtl/fdl_status.sv
module fdl_status #(
  parameter int BYTE_W = 8,
  parameter int ST_N   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              hit_i,
  input  logic              rd_data_i,
  input  logic              rd_stat_i,
  input  logic              wr_mask_i,
  input  logic [ST_N-1:0]   mask_wdata_i,
  output logic [BYTE_W-1:0] hold_o,
  output logic [ST_N-1:0]   stat_o,
  output logic [ST_N-1:0]   mask_o,
  output logic              irq_n_o
);
  import fdl_pkg::*;

  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              unread_q, unread_d;
  logic [ST_N-1:0]   stat_q, stat_d, set_v;
  logic [ST_N-1:0]   mask_q, mask_d;
  logic              irq_n_q, irq_n_d;

  always_comb begin
    set_v           = '0;
    set_v[ST_FULL]  = done_i;
    set_v[ST_MATCH] = done_i & hit_i;
    set_v[ST_OVR]   = done_i & unread_q & ~rd_data_i;

    stat_d = set_v | (rd_stat_i ? '0 : stat_q);

    hold_d   = hold_q;
    unread_d = unread_q;
    if (rd_data_i) unread_d = 1'b0;
    if (done_i) begin
      hold_d   = byte_i;
      unread_d = 1'b1;
    end

    mask_d = mask_q;
    if (wr_mask_i) mask_d = mask_wdata_i;

    irq_n_d = ~|(stat_d & mask_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      unread_q <= 1'b0;
      stat_q   <= '0;
      mask_q   <= '0;
      irq_n_q  <= 1'b1;
    end else begin
      hold_q   <= hold_d;
      unread_q <= unread_d;
      stat_q   <= stat_d;
      mask_q   <= mask_d;
      irq_n_q  <= irq_n_d;
    end
  end

  assign hold_o  = hold_q;
  assign stat_o  = stat_q;
  assign mask_o  = mask_q;
  assign irq_n_o = irq_n_q;
endmodule

// File: rtl/fdl_byte_rx.sv
module fdl_byte_rx #(
  parameter int BYTE_W  = 8,
  parameter int NUM_PAT = 2,
  parameter int ADDR_W  = 3,
  localparam int CNT_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  input  logic [ADDR_W-1:0] reg_sel_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              irq_n_o
);
  import fdl_pkg::*;

  logic                           done_w;
  logic [BYTE_W-1:0]              byte_w;
  logic [CNT_W-1:0]               cnt_w;
  logic                           hit_w;
  logic [NUM_PAT-1:0][BYTE_W-1:0] pat_w;
  logic [BYTE_W-1:0]              hold_w;
  logic [ST_W-1:0]                stat_w;
  logic [ST_W-1:0]                mask_w;
  logic                           rd_data, rd_stat, wr_mask;

  assign rd_data = reg_rd_i && (reg_sel_i == ADDR_W'(A_DATA));
  assign rd_stat = reg_rd_i && (reg_sel_i == ADDR_W'(A_STAT));
  assign wr_mask = reg_wr_i && (reg_sel_i == ADDR_W'(A_MASK));

  fdl_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
    .done_o(done_w), .byte_o(byte_w), .cnt_o(cnt_w)
  );

  fdl_match #(.BYTE_W(BYTE_W), .NUM_PAT(NUM_PAT), .AW(ADDR_W)) u_match (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .sel_i(reg_sel_i),
    .wdata_i(reg_wdata_i), .byte_i(byte_w), .hit_o(hit_w), .pat_o(pat_w)
  );

  fdl_status #(.BYTE_W(BYTE_W), .ST_N(ST_W)) u_status (
    .clk(clk), .rst_n(rst_n), .done_i(done_w), .byte_i(byte_w), .hit_i(hit_w),
    .rd_data_i(rd_data), .rd_stat_i(rd_stat), .wr_mask_i(wr_mask),
    .mask_wdata_i(reg_wdata_i[ST_W-1:0]), .hold_o(hold_w), .stat_o(stat_w),
    .mask_o(mask_w), .irq_n_o(irq_n_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_i == ADDR_W'(A_DATA))      reg_rdata_o = hold_w;
    else if (reg_sel_i == ADDR_W'(A_STAT)) reg_rdata_o = BYTE_W'(stat_w);
    else if (reg_sel_i == ADDR_W'(A_MASK)) reg_rdata_o = BYTE_W'(mask_w);
    else begin
      for (int i = 0; i < NUM_PAT; i++)
        if (reg_sel_i == ADDR_W'(A_PAT0 + i)) reg_rdata_o = pat_w[i];
    end
  end
endmodule

// File: rtl/fdl_byte_rx_chk.sv
module fdl_byte_rx_chk #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 3,
  parameter int ST_N   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_vld_i,
  input logic [ADDR_W-1:0] reg_sel_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [BYTE_W-1:0] reg_wdata_i,
  input logic              irq_n_o,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [ST_N-1:0]   stat_w,
  input logic [ST_N-1:0]   mask_w
);
  import fdl_pkg::*;

  // R6
  irq_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_o == ~|(stat_w & mask_w));

  // R5
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_sel_i == ADDR_W'(A_STAT) && !bit_vld_i) |=> (stat_w == '0));

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld_i |=> $stable(cnt_w));

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld_i && cnt_w != CNT_W'(BYTE_W-1)) |=> (cnt_w == $past(cnt_w) + CNT_W'(1)));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld_i |=> ((stat_w & ~$past(stat_w)) == '0));

  // R9
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_sel_i == ADDR_W'(A_MASK)) |=> (mask_w == $past(reg_wdata_i[ST_N-1:0])));
endmodule

bind fdl_byte_rx fdl_byte_rx_chk #(
  .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ST_N(fdl_pkg::ST_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld_i(bit_vld_i), .reg_sel_i(reg_sel_i),
  .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_wdata_i(reg_wdata_i),
  .irq_n_o(irq_n_o), .cnt_w(cnt_w), .stat_w(stat_w), .mask_w(mask_w)
);

// File: tb/fdl_byte_rx_tb.sv
module fdl_byte_rx_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_i, bit_vld_i;
  logic [2:0] reg_sel_i;
  logic       reg_wr_i, reg_rd_i;
  logic [7:0] reg_wdata_i, reg_rdata_o;
  logic       irq_n_o;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  // bench model
  logic [7:0] m_hold, m_pat0, m_pat1;
  logic [2:0] m_stat, m_mask;
  bit         m_unread;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdl_byte_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
    .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_n_o(irq_n_o)
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic exp_irq_n(logic [2:0] st, logic [2:0] mk);
    return ~|(st & mk);
  endfunction

  function automatic logic [2:0] byte_events(logic [7:0] b);
    logic [2:0] e;
    e    = 3'b001;
    e[1] = (b == m_pat0) || (b == m_pat1);
    e[2] = m_unread;
    return e;
  endfunction

  task automatic reg_wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_sel_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk);
    reg_wr_i = 1'b0;
    if (a == 3'd2) m_mask = d[2:0];
    if (a == 3'd3) m_pat0 = d;
    if (a == 3'd4) m_pat1 = d;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_sel_i = a; reg_rd_i = 1'b1;
    #1 d = reg_rdata_o;
    @(negedge clk);
    reg_rd_i = 1'b0;
    if (a == 3'd1) m_stat = 3'b000;
    if (a == 3'd0) m_unread = 0;
  endtask

  // send bits 0..n-1 of b, optionally with junk idle cycles between
  task automatic send_bits(logic [7:0] b, int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_i = b[i]; bit_vld_i = 1'b1;
      if (gaps) begin
        @(negedge clk);
        bit_vld_i = 1'b0; bit_i = 1'($urandom);
      end
    end
    @(negedge clk);
    bit_vld_i = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b, bit gaps);
    logic [2:0] e;
    e = byte_events(b);
    send_bits(b, 8, gaps);
    m_stat |= e; m_hold = b; m_unread = 1;
  endtask

  task automatic check_stat(string req);
    logic [7:0] d;
    reg_rd(3'd1, d);
    check(req, d, {5'b0, m_stat_prev});
    check({req, " irq"}, {7'b0, irq_n_o}, {7'b0, exp_irq_n(m_stat, m_mask)});
  endtask

  logic [2:0] m_stat_prev;

  task automatic read_stat_checked(string req);
    m_stat_prev = m_stat;
    check_stat(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, b, e8;
    logic [2:0] pre;
    void'($urandom(32'd4242));
    rst_n = 1'b0; bit_i = 0; bit_vld_i = 0; reg_sel_i = 0;
    reg_wr_i = 0; reg_rd_i = 0; reg_wdata_i = 0;
    m_hold = 0; m_pat0 = 0; m_pat1 = 0; m_stat = 0; m_mask = 0; m_unread = 0;
    m_stat_prev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state
    check("R7 irq", {7'b0, irq_n_o}, 8'h01);
    for (int a = 0; a < 5; a++) begin
      reg_rd(3'(a), d);
      check("R7 reg", d, 8'h00);
    end

    // R9 register readback and ignored writes
    reg_wr(3'd3, 8'hA5); reg_wr(3'd4, 8'h3C); reg_wr(3'd2, 8'h05);
    reg_rd(3'd3, d); check("R9 pat0", d, 8'hA5);
    reg_rd(3'd4, d); check("R9 pat1", d, 8'h3C);
    reg_rd(3'd2, d); check("R9 mask", d, 8'h05);
    reg_wr(3'd0, 8'hFF); reg_wr(3'd1, 8'hFF);
    reg_rd(3'd0, d); check("R9 data ro", d, 8'h00);
    reg_rd(3'd1, d); check("R9 stat ro", d, 8'h00);
    reg_wr(3'd2, 8'h00);

    // R1 / R2 basic byte, irq masked off
    send_byte(8'h5A, 0);
    check("R6 masked irq", {7'b0, irq_n_o}, 8'h01);
    reg_rd(3'd0, d); check("R1 data", d, 8'h5A);
    read_stat_checked("R2 full");

    // R8 junk between valid bits
    send_byte(8'h81, 1);
    reg_rd(3'd0, d); check("R8 gaps data", d, 8'h81);
    read_stat_checked("R8 stat");

    // R3 / R6 match interrupt
    reg_wr(3'd2, 8'h02);
    send_byte(8'h3C, 0);
    check("R6 match irq", {7'b0, irq_n_o}, 8'h00);
    reg_rd(3'd0, d); check("R3 data", d, 8'h3C);
    read_stat_checked("R3 match");
    check("R6 irq released", {7'b0, irq_n_o}, 8'h01);
    send_byte(8'h3D, 0);
    reg_rd(3'd0, d);
    read_stat_checked("R3 no match");

    // R4 overrun
    reg_wr(3'd2, 8'h04);
    send_byte(8'h11, 0);
    send_byte(8'h22, 0);
    check("R4 irq", {7'b0, irq_n_o}, 8'h00);
    reg_rd(3'd0, d); check("R4 newest", d, 8'h22);
    read_stat_checked("R4 ovr");

    // R4 data read colliding with completion: no overrun
    send_byte(8'h33, 0);
    send_bits(8'h44, 7, 0);
    @(negedge clk);
    bit_i = 1'b0; bit_vld_i = 1'b1; reg_sel_i = 3'd0; reg_rd_i = 1'b1;
    #1 d = reg_rdata_o;
    @(negedge clk);
    bit_vld_i = 1'b0; reg_rd_i = 1'b0;
    check("R4 collide old data", d, 8'h33);
    m_unread = 0; m_stat |= byte_events(8'h44); m_hold = 8'h44; m_unread = 1;
    reg_rd(3'd0, d); check("R4 collide new data", d, 8'h44);
    read_stat_checked("R4 collide stat");

    // R5 status read colliding with completion
    reg_wr(3'd2, 8'h07);
    send_byte(8'hA5, 0);
    send_bits(8'h01, 7, 0);
    pre = m_stat;
    @(negedge clk);
    bit_i = 1'b0; bit_vld_i = 1'b1; reg_sel_i = 3'd1; reg_rd_i = 1'b1;
    #1 d = reg_rdata_o;
    @(negedge clk);
    bit_vld_i = 1'b0; reg_rd_i = 1'b0;
    check("R5 collide read", d, {5'b0, pre});
    m_stat = byte_events(8'h01); m_hold = 8'h01; m_unread = 1;
    check("R5 collide irq", {7'b0, irq_n_o}, {7'b0, exp_irq_n(m_stat, m_mask)});
    read_stat_checked("R5 collide kept");
    reg_rd(3'd0, d); check("R1 collide byte", d, 8'h01);

    // random phase
    for (int k = 0; k < 60; k++) begin
      if (($urandom % 4) == 0) reg_wr(3'd2, 8'($urandom));
      b = 8'($urandom);
      if (($urandom % 4) == 0) b = (($urandom % 2) != 0) ? m_pat0 : m_pat1;
      send_byte(b, ($urandom % 3) == 0);
      check("R6 rand irq", {7'b0, irq_n_o}, {7'b0, exp_irq_n(m_stat, m_mask)});
      if (($urandom % 3) != 0) begin
        e8 = m_hold;
        reg_rd(3'd0, d); check("R1 rand data", d, e8);
      end
      if (($urandom % 2) != 0) read_stat_checked("R5 rand stat");
    end

    ended = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule